// File: doc/BRIEF.md
# One-Time-Programmable Configuration Serial Loader

This block is the receiving state machine of a serial interface that writes a one-time-programmable configuration word. It watches three slow external pins: a chip select, a serial clock, and a combined data/programming pin. It also watches a digital flag that stands in for detection of the programming voltage. All four are brought into the system clock domain through a synchronizer. The loader enters programming mode on one pin condition only. It then shifts in a 16-bit word, counts the burn clock pulses and writes the word into a model of the fuse register.

The fuse register keeps its contents across the synchronous reset, which here plays the part of a power-on reset. The decoded configuration outputs come from a shadow copy of the fuses. That copy is reloaded only while reset is held, so a freshly burned word becomes visible only after the next power cycle. A device that was never burned shows every field as zero. Programming mode is left only through reset. Once a burn has completed, the fuses accept no further change in the same power cycle. A later power cycle may burn a new word, which replaces the stored one.

Top module: `otp_cfg_loader`

## Requirements
- R1: While reset is held and after it is released, `prog_mode`, `load_err` and `burn_done` are 0. On a device never burned, every configuration output is 0.
- R2: Programming mode (`prog_mode`=1) is entered only on a rising edge of `cs_n` that occurs while `prog_din` is 1 and `sclk` is 0. A `cs_n` rise with `prog_din`=0, or with `sclk`=1, leaves `prog_mode` at 0.
- R3: In programming mode, with `vprog_ok` low, `prog_din` is sampled on each rising edge of `sclk`. The fields arrive in a fixed order: `cfg_ccw` comes first, then `cfg_zero` MSB first (bit 9 down to bit 0), then `cfg_idx_wide`, then `cfg_div` bit 1 and bit 0, then `cfg_mode` bit 1 and bit 0.
- R4: Bits received after the 16th are ignored and do not alter the stored word.
- R5: If `vprog_ok` rises before 16 bits have arrived, `load_err` becomes 1. No burn takes place: `burn_done` stays 0 and the configuration outputs are unchanged after the next reset.
- R6: After 16 bits have been received and `vprog_ok` has risen, the burn completes on the 16th rising `sclk` edge seen while `vprog_ok` is high. `burn_done` is still 0 after 15 edges and is 1 after the 16th.
- R7: `prog_mode` stays 1 until reset, including through further `cs_n` pulses. The configuration outputs keep their power-up values until the next reset and show the burned word after that reset.
- R8: After a burn, further entry, shift and burn activity in the same power cycle leaves the fuses unchanged. The next reset shows the first burned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, modelling power-on reset |
| cs_n | input | 1 | Chip select pin, asynchronous |
| sclk | input | 1 | Serial clock pin, asynchronous |
| prog_din | input | 1 | Serial data / programming pin, asynchronous |
| vprog_ok | input | 1 | Digital flag: programming voltage present |
| prog_mode | output | 1 | Programming mode active |
| load_err | output | 1 | Voltage flag rose before the word was complete |
| burn_done | output | 1 | Fuse burn completed, fuses locked |
| cfg_ccw | output | 1 | Direction bit from fuses |
| cfg_zero | output | 10 | Zero position from fuses |
| cfg_idx_wide | output | 1 | Index pulse width select from fuses |
| cfg_div | output | 2 | Divider setting from fuses |
| cfg_mode | output | 2 | Output mode selection from fuses |

## Verification
The embedded assertions check these rules on every cycle:
- programming mode begins only after a qualified chip-select rise, and it never drops while reset is high;
- the received word freezes once it is full;
- a burn finishes only when the pulse counter reaches its last value;
- an error state never writes the fuses, and the fuses never change after a burn;
- the configuration outputs stay still between resets.

Some behaviour shows only at the ports across a power cycle, so only the bench scenarios can demonstrate it. That covers the mapping of each serial position onto its field, the rejection of non-qualifying entry conditions, the exact 15-versus-16 pulse boundary, and the rule that a second burn in one power cycle is lost. The bench sweeps every one-hot word and several dense patterns.

// File: rtl/otp_cfg_pkg.sv
// Package: shared types of the OTP configuration loader.
// The packed field order equals the serial arrival order, so the first
// bit received lands in the most significant position of the word.
package otp_cfg_pkg;

    localparam int ZERO_BITS = 10;

    typedef struct packed {
        logic                 ccw;
        logic [ZERO_BITS-1:0] zero;
        logic                 idx_wide;
        logic [1:0]           div;
        logic [1:0]           mode;
    } cfg_t;

    localparam int CFG_BITS = $bits(cfg_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_BURN,
        ST_DONE,
        ST_FAIL
    } ld_state_t;

endpackage

// File: rtl/otp_in_sync.sv
// Module: multi-stage synchronizer for a vector of slow asynchronous pins.
// Assumes STAGES >= 1 and that pins are held many clocks per level.
// RESET_VAL gives each bit its idle level so that leaving reset makes no
// false edge.
module otp_in_sync #(
    parameter int           N         = 4,
    parameter int           STAGES    = 2,
    parameter logic [N-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [STAGES-1:0][N-1:0] stg_q;

    // Shift the pin vector through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RESET_VAL;
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/otp_shift_rx.sv
// Module: serial receive shifter with a saturating bit counter.
// Shifts left, so the first bit ends in the MSB. Once WORD_BITS bits are
// held, further enables are ignored. Assumes en is a one-cycle strobe.
module otp_shift_rx #(
    parameter int WORD_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 din,
    output logic [WORD_BITS-1:0] word,
    output logic                 full
);

    localparam int               CW       = $clog2(WORD_BITS + 1);
    localparam logic [CW-1:0]    FULL_CNT = CW'(WORD_BITS);

    logic [CW-1:0] cnt_q;

    assign full = (cnt_q == FULL_CNT);

    // Accept one bit per strobe until the word is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            cnt_q <= '0;
        end else if (en && !full) begin
            word  <= {word[WORD_BITS-2:0], din};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: once full, a strobe must not alter the held word.
    a_r4_frozen_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> $stable(word));

endmodule

// File: rtl/otp_burn_ctl.sv
// Module: programming-mode sequencer, burn pulse counter, fuse model and
// power-up shadow of the fuses.
// Assumes synchronized pin levels. The fuse register has no reset, so it
// survives rst_n. The shadow is reloaded from it only while rst_n is low.
module otp_burn_ctl
    import otp_cfg_pkg::*;
#(
    parameter int BURN_PULSES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_s,
    input  logic                sclk_s,
    input  logic                prog_s,
    input  logic                vprog_s,
    input  logic                word_full,
    input  logic [CFG_BITS-1:0] word,
    output logic                shift_en,
    output logic                prog_mode,
    output logic                load_err,
    output logic                burn_done,
    output cfg_t                cfg
);

    localparam int            BW       = $clog2(BURN_PULSES + 1);
    localparam logic [BW-1:0] LAST_CNT = BW'(BURN_PULSES - 1);

    ld_state_t           st_q;
    logic                cs_d, sclk_d, vprog_d;
    logic                cs_rise, sclk_rise, vprog_rise;
    logic [BW-1:0]       pulse_q;
    logic [CFG_BITS-1:0] fuse_q = '0;
    cfg_t                shadow_q;
    logic                burn_fire;

    // Remember the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d    <= 1'b1;
            sclk_d  <= 1'b0;
            vprog_d <= 1'b0;
        end else begin
            cs_d    <= cs_s;
            sclk_d  <= sclk_s;
            vprog_d <= vprog_s;
        end
    end

    assign cs_rise    = cs_s && !cs_d;
    assign sclk_rise  = sclk_s && !sclk_d;
    assign vprog_rise = vprog_s && !vprog_d;

    assign shift_en  = (st_q == ST_SHIFT) && sclk_rise && !vprog_s;
    assign burn_fire = (st_q == ST_BURN) && sclk_rise && vprog_s
                       && (pulse_q == LAST_CNT);

    // Sequencer: entry, shifting, burning and terminal states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            pulse_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE:  if (cs_rise && prog_s && !sclk_s) st_q <= ST_SHIFT;
                ST_SHIFT: if (vprog_rise) st_q <= word_full ? ST_BURN : ST_FAIL;
                ST_BURN: begin
                    if (burn_fire)                   st_q    <= ST_DONE;
                    else if (sclk_rise && vprog_s)   pulse_q <= pulse_q + 1'b1;
                end
                default: st_q <= st_q;
            endcase
        end
    end

    // Fuse model: written once when the burn completes, never reset.
    always_ff @(posedge clk) begin
        if (rst_n && burn_fire) fuse_q <= word;
    end

    // Power-up shadow: captures the fuses while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= cfg_t'(fuse_q);
    end

    assign prog_mode = (st_q != ST_IDLE);
    assign load_err  = (st_q == ST_FAIL);
    assign burn_done = (st_q == ST_DONE);
    assign cfg       = shadow_q;

    // R2: programming mode starts only after a qualified chip-select rise.
    a_r2_entry_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_mode) |-> $past(cs_rise && prog_s && !sclk_s));

    // R7: programming mode is only left through reset.
    a_r7_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prog_mode |=> prog_mode);

    // R7: configuration outputs are still between resets.
    a_r7_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg));

    // R6: a burn completes only on the last counted pulse.
    a_r6_burn_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burn_done) |-> $past(pulse_q) == LAST_CNT);

    // R8: fuses never change once the burn is done.
    a_r8_fuse_locked: assert property (@(posedge clk) disable iff (!rst_n)
        burn_done |=> $stable(fuse_q));

    // R5: an incomplete load neither burns nor leaves the error state.
    a_r5_no_burn_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |=> load_err && $stable(fuse_q));

endmodule

// File: rtl/otp_cfg_loader.sv
// Module: top of the OTP configuration serial loader.
// Synchronizes the pins, receives the 16-bit word and drives the sequencer.
// Assumes every pin level is held for longer than SYNC_STAGES + 2 clocks.
module otp_cfg_loader
    import otp_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BURN_PULSES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 prog_din,
    input  logic                 vprog_ok,
    output logic                 prog_mode,
    output logic                 load_err,
    output logic                 burn_done,
    output logic                 cfg_ccw,
    output logic [ZERO_BITS-1:0] cfg_zero,
    output logic                 cfg_idx_wide,
    output logic [1:0]           cfg_div,
    output logic [1:0]           cfg_mode
);

    localparam int PIN_N = 4;

    logic [PIN_N-1:0]    pins_s;
    logic                shift_en, word_full;
    logic [CFG_BITS-1:0] word;
    cfg_t                cfg;

    otp_in_sync #(
        .N         (PIN_N),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (4'b0001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({vprog_ok, prog_din, sclk, cs_n}),
        .dout  (pins_s)
    );

    otp_shift_rx #(
        .WORD_BITS (CFG_BITS)
    ) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (shift_en),
        .din   (pins_s[2]),
        .word  (word),
        .full  (word_full)
    );

    otp_burn_ctl #(
        .BURN_PULSES (BURN_PULSES)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (pins_s[0]),
        .sclk_s    (pins_s[1]),
        .prog_s    (pins_s[2]),
        .vprog_s   (pins_s[3]),
        .word_full (word_full),
        .word      (word),
        .shift_en  (shift_en),
        .prog_mode (prog_mode),
        .load_err  (load_err),
        .burn_done (burn_done),
        .cfg       (cfg)
    );

    assign cfg_ccw      = cfg.ccw;
    assign cfg_zero     = cfg.zero;
    assign cfg_idx_wide = cfg.idx_wide;
    assign cfg_div      = cfg.div;
    assign cfg_mode     = cfg.mode;

endmodule

// File: tb/otp_cfg_loader_test.sv
// Bench: sweeps one-hot and dense words through entry, shift, burn and
// power cycle, and checks every field against arithmetic expectations.
module otp_cfg_loader_test;

    localparam int HOLD = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       prog_din = 1'b0;
    logic       vprog_ok = 1'b0;
    logic       prog_mode, load_err, burn_done;
    logic       cfg_ccw, cfg_idx_wide;
    logic [9:0] cfg_zero;
    logic [1:0] cfg_div, cfg_mode;

    int checks = 0;
    int errors = 0;

    otp_cfg_loader uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .prog_din(prog_din), .vprog_ok(vprog_ok),
        .prog_mode(prog_mode), .load_err(load_err), .burn_done(burn_done),
        .cfg_ccw(cfg_ccw), .cfg_zero(cfg_zero), .cfg_idx_wide(cfg_idx_wide),
        .cfg_div(cfg_div), .cfg_mode(cfg_mode)
    );

    always #10 clk = ~clk;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic power_cycle();
        vprog_ok = 1'b0; prog_din = 1'b0; sclk = 1'b0; cs_n = 1'b1;
        rst_n = 1'b0;
        wait_clk(HOLD);
        rst_n = 1'b1;
        wait_clk(HOLD);
    endtask

    task automatic cs_pulse(input logic p, input logic c);
        cs_n = 1'b0; prog_din = p; sclk = c;
        wait_clk(HOLD);
        cs_n = 1'b1;
        wait_clk(HOLD);
        sclk = 1'b0;
        wait_clk(HOLD);
    endtask

    task automatic send_bit(input logic b);
        prog_din = b;
        wait_clk(HOLD);
        sclk = 1'b1;
        wait_clk(HOLD);
        sclk = 1'b0;
        wait_clk(HOLD);
    endtask

    task automatic send_word(input logic [15:0] w, input int nbits);
        for (int i = 15; i > 15 - nbits; i--) send_bit(w[i]);
    endtask

    task automatic burn_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; wait_clk(HOLD);
            sclk = 1'b0; wait_clk(HOLD);
        end
    endtask

    task automatic raise_vprog();
        prog_din = 1'b1; vprog_ok = 1'b1;
        wait_clk(HOLD);
    endtask

    task automatic check_fields(input string req, input logic [15:0] w);
        chk(req, int'(cfg_ccw), int'((w >> 15) & 16'h1));
        chk(req, int'(cfg_zero), int'((w >> 5) & 16'h3FF));
        chk(req, int'(cfg_idx_wide), int'((w >> 4) & 16'h1));
        chk(req, int'(cfg_div), int'((w >> 2) & 16'h3));
        chk(req, int'(cfg_mode), int'(w & 16'h3));
    endtask

    function automatic logic [15:0] pick(input int k);
        if (k < 16) return 16'h1 << k;
        else if (k == 16) return 16'hFFFF;
        else if (k == 17) return 16'hA5C3;
        else return 16'h5A3C;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] prev;
        wait_clk(4);
        // R1: state during reset
        chk("R1", int'({prog_mode, load_err, burn_done}), 0);
        rst_n = 1'b1;
        wait_clk(HOLD);
        chk("R1", int'({prog_mode, load_err, burn_done}), 0);
        check_fields("R1", 16'h0);

        // R2: non-qualifying chip-select rises
        cs_pulse(1'b0, 1'b0);
        chk("R2", int'(prog_mode), 0);
        cs_pulse(1'b1, 1'b1);
        chk("R2", int'(prog_mode), 0);
        cs_pulse(1'b0, 1'b1);
        chk("R2", int'(prog_mode), 0);

        prev = 16'h0;
        for (int k = 0; k < 19; k++) begin
            logic [15:0] w;
            w = pick(k);
            cs_pulse(1'b1, 1'b0);
            chk("R2", int'(prog_mode), 1);
            if (k == 0) begin
                send_word(w, 8);
                cs_pulse(1'b1, 1'b0);
                chk("R7", int'(prog_mode), 1);
                for (int i = 7; i >= 0; i--) send_bit(w[i]);
            end else begin
                send_word(w, 16);
            end
            // R4: extra bits with inverted values on odd iterations
            if (k % 2 == 1) begin
                send_bit(~w[0]); send_bit(~w[1]); send_bit(~w[2]);
            end
            raise_vprog();
            chk("R5", int'(load_err), 0);
            burn_pulses(15);
            chk("R6", int'(burn_done), 0);
            burn_pulses(1);
            chk("R6", int'(burn_done), 1);
            chk("R7", int'(prog_mode), 1);
            // R7: outputs still show the power-up value
            check_fields("R7", prev);
            power_cycle();
            chk("R7", int'(prog_mode), 0);
            check_fields(k % 2 == 1 ? "R4" : "R3", w);
            prev = w;
        end

        // R8: second burn attempt in the same power cycle is lost
        cs_pulse(1'b1, 1'b0);
        send_word(16'h1234, 16);
        raise_vprog();
        burn_pulses(16);
        chk("R8", int'(burn_done), 1);
        vprog_ok = 1'b0;
        wait_clk(HOLD);
        cs_pulse(1'b1, 1'b0);
        send_word(16'hFEDC, 16);
        raise_vprog();
        burn_pulses(16);
        power_cycle();
        check_fields("R8", 16'h1234);

        // R5: voltage flag before the word is complete
        cs_pulse(1'b1, 1'b0);
        send_word(16'h0F0F, 10);
        raise_vprog();
        chk("R5", int'(load_err), 1);
        burn_pulses(16);
        chk("R5", int'(burn_done), 0);
        power_cycle();
        chk("R5", int'(load_err), 0);
        check_fields("R5", 16'h1234);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule